// File: doc/BRIEF.md
# Timebase Periodic Interrupt Generator

This block divides a timebase clock-enable stream with a free-running 14-bit counter. Each time the counter tap chosen by a two-bit rate field wraps, the block sets a sticky timeout flag. When the interrupt enable is also set, the flag raises an interrupt request. Software reads and writes a single 8-bit control/status byte over a simple select/write/data bus. The divider counter is never cleared, so after reset the first timeout comes after an unknown delay. Every later timeout comes exactly one selected period after the one before it.

The same byte holds three further controls. The first is a flag-clear strobe bit. The second is a watchdog-enable bit that takes the value of the first write after reset and then stays fixed. The third is a watchdog-clear bit that sends a single-cycle pulse to an external watchdog. The strobe bits always read back as zero, as does the unused bit.

Top module: `tbase_irq_gen`

## Requirements
- R1: After reset the register reads 0x30: rate field (bits 5:4) = 11, and flag (bit 7), interrupt enable (bit 6) and watchdog enable (bit 1) are all 0. `irq`, `wdog_en` and `wdog_clr` are low.
- R2: The flag sets once per selected period, counted in `tb_ce` pulses. Rate field 00 gives 128, 01 gives 4096, 10 gives 8192 and 11 gives 16384.
- R3: A write to bit 7 never changes the flag, whether it writes 0 or 1.
- R4: Writing 1 to bit 3 clears the flag on the write edge. Writing 0 to bit 3 leaves the flag unchanged.
- R5: If a timeout falls on the same clock edge as a bit-3 clear write, the flag ends up 1.
- R6: `irq` is high exactly when the flag and the interrupt enable (bit 6) are both 1.
- R7: Bits 3, 2 and 0 always read as 0.
- R8: The first register write after reset loads bit 1 into `wdog_en`. Every later write leaves it unchanged until the next reset.
- R9: A write with bit 0 = 1 produces a one-cycle `wdog_clr` pulse in the cycle after the write edge. A write with bit 0 = 0 produces no pulse.
- R10: The divider advances only on cycles where `tb_ce` is high. With `tb_ce` held low, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_ce | input | 1 | Timebase clock enable; one divider step per high cycle |
| reg_sel | input | 1 | Register address decode hit |
| reg_wr | input | 1 | Write strobe, qualified by `reg_sel` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when `reg_sel` is low |
| irq | output | 1 | Timebase interrupt request |
| wdog_en | output | 1 | Write-once watchdog enable |
| wdog_clr | output | 1 | One-cycle watchdog clear pulse |

## Verification
The period is measured with `tb_ce` held high for all four rate codes. This separates the four tap widths and shows that each tap wraps on a full period and not one count early or late. A run with `tb_ce` toggling every cycle must double the period, which shows the divider counts enables and not clocks. A run with `tb_ce` held low must give no timeout at all. A clear write placed on the exact timeout edge separates set-priority from clear-priority, and the register writes with bit 7, bit 3 and bit 0 set and cleared tell the read-only, strobe and write-once fields apart.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  localparam int unsigned TB_DATA_W = 8;
  localparam int unsigned TB_RATES  = 4;
  localparam int unsigned TB_RATE_W = $clog2(TB_RATES);

  // Register bit positions
  localparam int unsigned BIT_FLAG  = 7;
  localparam int unsigned BIT_IE    = 6;
  localparam int unsigned BIT_RATE  = 4;  // two bits: 5:4
  localparam int unsigned BIT_CLR   = 3;
  localparam int unsigned BIT_WDEN  = 1;
  localparam int unsigned BIT_WDCLR = 0;

  typedef enum logic [TB_RATE_W-1:0] {
    RATE_SHORT = 2'b00,
    RATE_MID   = 2'b01,
    RATE_LONG  = 2'b10,
    RATE_MAX   = 2'b11
  } rate_e;

endpackage

// File: rtl/tbase_rst_sync.sv
module tbase_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/tbase_divider.sv
module tbase_divider
  import tbase_pkg::*;
#(
  parameter int unsigned DIV_W = 14,
  parameter int unsigned TAPS [TB_RATES] = '{7, 12, 13, 14}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tb_ce,
  input  logic [TB_RATE_W-1:0] rate,
  output logic                 tick
);

  logic [DIV_W-1:0]    cnt_q;
  logic [DIV_W-1:0]    cnt_d;
  logic [TB_RATES-1:0] tap_hit;

  // Next-state: count only on enabled cycles
  always_comb begin
    cnt_d = cnt_q;
    if (tb_ce) cnt_d = cnt_q + 1'b1;
  end

  // Free-running divider: deliberately not reset
  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  // One wrap detector per selectable tap
  for (genvar g = 0; g < TB_RATES; g++) begin : g_tap
    assign tap_hit[g] = &cnt_q[TAPS[g]-1:0];
  end

  assign tick = tb_ce & tap_hit[rate];

  // R10: divider holds when the enable is low
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_ce |=> $stable(cnt_q));

endmodule

// File: rtl/tbase_csr.sv
module tbase_csr
  import tbase_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 wr,
  input  logic [TB_DATA_W-1:0] wdata,
  input  logic                 tick,
  output logic [TB_DATA_W-1:0] rdata,
  output logic                 flag,
  output logic                 ie,
  output logic [TB_RATE_W-1:0] rate,
  output logic                 wd_en,
  output logic                 wd_clr
);

  logic  wr_hit;
  logic  clr_req;
  logic  flag_q, flag_d;
  logic  ie_q, ie_d;
  rate_e rate_q, rate_d;
  logic  wden_q, wden_d;
  logic  lock_q, lock_d;
  logic  wdclr_q, wdclr_d;

  assign wr_hit  = sel & wr;
  assign clr_req = wr_hit & wdata[BIT_CLR];

  // Next-state logic
  always_comb begin
    flag_d  = flag_q;
    ie_d    = ie_q;
    rate_d  = rate_q;
    wden_d  = wden_q;
    lock_d  = lock_q | wr_hit;
    wdclr_d = wr_hit & wdata[BIT_WDCLR];
    if (clr_req) flag_d = 1'b0;
    if (tick)    flag_d = 1'b1;  // timeout has priority over clear
    if (wr_hit) begin
      ie_d   = wdata[BIT_IE];
      rate_d = rate_e'(wdata[BIT_RATE +: TB_RATE_W]);
      if (!lock_q) wden_d = wdata[BIT_WDEN];
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      rate_q  <= RATE_MAX;
      wden_q  <= 1'b0;
      lock_q  <= 1'b0;
      wdclr_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      ie_q    <= ie_d;
      rate_q  <= rate_d;
      wden_q  <= wden_d;
      lock_q  <= lock_d;
      wdclr_q <= wdclr_d;
    end
  end

  // Read mux: strobe and unused bits return zero
  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[BIT_FLAG]                 = flag_q;
      rdata[BIT_IE]                   = ie_q;
      rdata[BIT_RATE +: TB_RATE_W]    = rate_q;
      rdata[BIT_WDEN]                 = wden_q;
    end
  end

  assign flag   = flag_q;
  assign ie     = ie_q;
  assign rate   = rate_q;
  assign wd_en  = wden_q;
  assign wd_clr = wdclr_q;

  p_timeout_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag_q);

  p_flag_only_changes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_req) |=> $stable(flag_q));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !tick) |=> !flag_q);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && tick) |=> flag_q);

  p_zero_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[3] == 1'b0) && (rdata[2] == 1'b0) && (rdata[0] == 1'b0));

  p_wden_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(wden_q));

  p_wdclr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdclr_q && !(wr_hit && wdata[BIT_WDCLR])) |=> !wdclr_q);

endmodule

// File: rtl/tbase_irq_gen.sv
module tbase_irq_gen
  import tbase_pkg::*;
#(
  parameter int unsigned DIV_W = 14,
  parameter int unsigned TAPS [TB_RATES] = '{7, 12, 13, 14},
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tb_ce,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [TB_DATA_W-1:0] reg_wdata,
  output logic [TB_DATA_W-1:0] reg_rdata,
  output logic                 irq,
  output logic                 wdog_en,
  output logic                 wdog_clr
);

  logic                 rst_n_s;
  logic                 tick;
  logic                 flag;
  logic                 ie;
  logic [TB_RATE_W-1:0] rate;

  tbase_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  tbase_divider #(.DIV_W(DIV_W), .TAPS(TAPS)) u_div (
    .clk   (clk),
    .rst_n (rst_n_s),
    .tb_ce (tb_ce),
    .rate  (rate),
    .tick  (tick)
  );

  tbase_csr u_csr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .sel    (reg_sel),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .tick   (tick),
    .rdata  (reg_rdata),
    .flag   (flag),
    .ie     (ie),
    .rate   (rate),
    .wd_en  (wdog_en),
    .wd_clr (wdog_clr)
  );

  assign irq = flag & ie;

  // R6: request agrees with the readable flag and enable
  p_irq_matches_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !reg_sel || (irq == (reg_rdata[BIT_FLAG] && reg_rdata[BIT_IE])));

endmodule

// File: tb/sim_tbase_irq_gen.sv
module sim_tbase_irq_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_ce = 1'b1;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       wdog_en;
  logic       wdog_clr;

  int ce_mode = 0;  // 0 = always high, 1 = toggle, 2 = held low
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    int    exp;
  } item_t;

  item_t exp_q[$];
  int    act_q[$];

  always #10 clk = ~clk;  // 50 MHz

  tbase_irq_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_ce     (tb_ce),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .wdog_en   (wdog_en),
    .wdog_clr  (wdog_clr)
  );

  always @(negedge clk) begin
    if (ce_mode == 1)      tb_ce = ~tb_ce;
    else if (ce_mode == 2) tb_ce = 1'b0;
    else                   tb_ce = 1'b1;
  end

  // Scoreboard monitor: pairs expected items with observed results
  initial begin
    forever begin
      @(posedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        item_t it;
        int    a;
        it = exp_q.pop_front();
        a  = act_q.pop_front();
        checks++;
        if (a != it.exp) begin
          errors++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", it.req, a, it.exp);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    exp_q.push_back('{req, exp});
    act_q.push_back(act);
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(output logic [7:0] d);
    reg_sel = 1'b1; reg_wr = 1'b0;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Measures falling edges between two successive flag settings; ends at a set
  task automatic measure(input logic [1:0] r, input int expect_n, input string req);
    logic [7:0] ctl;
    int n;
    ctl = 8'h40 | (8'(r) << 4) | 8'h08;
    wr(ctl);
    n = 0;
    while (!irq && n < 70000) begin @(negedge clk); n++; end
    wr(ctl);
    check({req, " R4 clear after timeout"}, int'(irq), 0);
    n = 1;
    while (!irq && n < 4 * expect_n + 8) begin @(negedge clk); n++; end
    check(req, n, expect_n);
  endtask

  initial begin
    logic [7:0] d;
    int hits;

    do_reset();
    rd(d);
    check("R1 reset readback", d, 8'h30);
    check("R1 irq after reset", int'(irq), 0);
    check("R1 wdog_en after reset", int'(wdog_en), 0);
    check("R1 wdog_clr after reset", int'(wdog_clr), 0);

    // First write locks bit 1 high
    @(negedge clk);
    wr(8'h02);
    check("R8 first write loads wdog_en", int'(wdog_en), 1);
    rd(d);
    check("R8 readback after first write", int'(d & 8'h7F), 8'h02);
    @(negedge clk);
    wr(8'h30);
    check("R8 later write ignored", int'(wdog_en), 1);
    rd(d);
    check("R8 readback after second write", int'(d & 8'h7F), 8'h32);

    // Periods with the enable held high
    @(negedge clk);
    measure(2'b00, 128, "R2 period 128");

    // R5: clear write lands on the timeout edge
    wr(8'h48);
    repeat (126) @(negedge clk);
    wr(8'h48);
    check("R5 set wins over clear", int'(irq), 1);

    measure(2'b01, 4096, "R2 period 4096");
    measure(2'b10, 8192, "R2 period 8192");
    measure(2'b11, 16384, "R2 period 16384");

    // Flag is set here; long window before the next timeout
    wr(8'h30);
    check("R6 irq low with enable off", int'(irq), 0);
    rd(d);
    check("R3 R4 writing zeros keeps flag", int'(d & 8'h80), 8'h80);
    @(negedge clk);
    wr(8'h70);
    check("R6 irq high with flag and enable", int'(irq), 1);
    wr(8'h38);
    rd(d);
    check("R4 clear via bit 3", d, 8'h32);
    @(negedge clk);
    wr(8'hB0);
    rd(d);
    check("R3 writing 1 to bit 7 ignored", d, 8'h32);
    @(negedge clk);
    wr(8'h31);
    check("R9 clear pulse high", int'(wdog_clr), 1);
    @(negedge clk);
    check("R9 clear pulse one cycle", int'(wdog_clr), 0);
    wr(8'h30);
    check("R9 no pulse for bit0 = 0", int'(wdog_clr), 0);
    wr(8'hBD);
    rd(d);
    check("R7 bits 3 2 0 read zero", d, 8'h32);

    // Enable toggling: period doubles
    @(negedge clk);
    ce_mode = 1;
    measure(2'b00, 256, "R10 R2 half-rate enable");

    // Enable held low: no timeout
    ce_mode = 2;
    @(negedge clk);
    wr(8'h48);
    hits = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
    check("R10 no timeout without enable", hits, 0);
    ce_mode = 0;
    hits = 0;
    while (!irq && hits < 300) begin @(negedge clk); hits++; end
    check("R10 timeout resumes with enable", int'(irq), 1);

    // Second reset: first write with bit 1 = 0 locks it low
    do_reset();
    rd(d);
    check("R1 readback after second reset", d, 8'h30);
    check("R1 wdog_en cleared by reset", int'(wdog_en), 0);
    @(negedge clk);
    wr(8'h30);
    wr(8'h32);
    check("R8 locked low by first write", int'(wdog_en), 0);

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule